// File: doc/BRIEF.md
# SCSI Receive Parity and Attention Control

This block watches bytes arriving from an 8-bit SCSI data bus and checks each one for odd parity. When checking is switched on, a bad byte sets a sticky error flag that software later clears. The flag can also raise an interrupt through a mask. A second checker sits where buffered bytes move from the SCSI-side FIFO toward the DMA-side FIFO. Parity is not carried past that point, so the block computes fresh parity for the host-side copy of that data.

In initiator mode the block can raise the attention line on its own when a bad byte is received. This happens only when both parity checking and auto-attention are enabled. Attention goes high in the same cycle the bad byte is taken, so it is already high while acknowledge is still asserted for that byte. The transfer itself carries on. The block holds attention until a phase-change pulse arrives.

The block also drives the select line during a selection attempt. During selection, attention follows the manual request. If the attempt times out, select and attention both drop in the same cycle.

Top module: `rx_parity_attn`

## Requirements
- R1: A received byte counts only when byte_stb and ack_in are both high. Parity is good when the XOR of the data bits and par_in equals 1. When chk_en is high, a counted byte with bad parity sets perr_stat on the next clock, in both initiator and target mode. A good byte, or a strobe while ack_in is low, leaves perr_stat unchanged.
- R2: When chk_en is low, no parity error from either checker sets perr_stat.
- R3: perr_stat stays set until a clr_stb cycle. If a new error arrives in the same cycle as clr_stb, the error wins and perr_stat stays set.
- R4: irq equals perr_stat ANDed with irq_mask_en.
- R5: atn_out goes high combinationally in the same cycle as a counted bad byte, while ack_in is still high. This requires initiator=1, chk_en=1 and auto_atn_en=1.
- R6: If auto_atn_en is low, chk_en is low, or initiator is low (target mode), a parity error never drives atn_out.
- R7: Automatic attention stays high until a phase_chg pulse. From the next cycle on, atn_out follows man_atn alone.
- R8: While sel_req is high, sel_out and atn_out (atn_out = man_atn) are driven. In a sel_timeout cycle both drop in that same cycle and stay low until sel_req falls. Once sel_req is low, atn_out follows man_atn again.
- R9: When chk_en is high, a fifo_stb byte with bad odd parity on fifo_dat/fifo_par sets perr_stat on the next clock.
- R10: host_par is the odd parity of fifo_dat, that is, the inverted XOR of its bits.
- R11: After reset, atn_out, sel_out, perr_stat and irq are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_dat | input | DW | Data byte received from the bus |
| rx_par | input | 1 | Parity bit received with rx_dat |
| byte_stb | input | 1 | A received byte is present |
| ack_in | input | 1 | Acknowledge handshake for the current byte |
| initiator | input | 1 | 1 = initiator mode, 0 = target mode |
| chk_en | input | 1 | Enables parity checking |
| auto_atn_en | input | 1 | Enables attention on a parity error |
| man_atn | input | 1 | Manual attention request |
| sel_req | input | 1 | Selection attempt in progress |
| sel_timeout | input | 1 | Pulse: selection has timed out |
| phase_chg | input | 1 | Pulse: target changed bus phase |
| clr_stb | input | 1 | Pulse from software: clears perr_stat |
| irq_mask_en | input | 1 | Lets perr_stat reach irq |
| fifo_dat | input | DW | Data moving from the SCSI FIFO to the DMA FIFO |
| fifo_par | input | 1 | Parity bit carried with fifo_dat |
| fifo_stb | input | 1 | fifo_dat is valid |
| host_par | output | 1 | Freshly generated odd parity for fifo_dat |
| sel_out | output | 1 | Select line |
| atn_out | output | 1 | Attention line |
| perr_stat | output | 1 | Sticky parity-error status bit |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default DW=8. At this width all 256 byte values can be swept through the host-side parity generator, and every single-bit parity error is cheap to build. The directed tasks pair each enable setting, initiator with target mode, and an acknowledge that is low or high. They sample attention in the same cycle as the strobe, which shows that it rises while acknowledge is held. The timeout case checks select and attention in the very cycle of the timeout pulse.

// File: rtl/scsi_par_pkg.sv
package scsi_par_pkg;
    localparam int DEF_DW = 8;

    typedef struct packed {
        logic take;
        logic bad;
    } chk_res_t;

    function automatic logic odd_good(input logic [DEF_DW-1:0] d, input logic p);
        return ^{d, p};
    endfunction
endpackage

// File: rtl/par_checker.sv
module par_checker #(
    parameter int W = 8
) (
    input  logic [W-1:0] dat,
    input  logic         par,
    input  logic         stb,
    output scsi_par_pkg::chk_res_t res,
    output logic         gen_par
);
    logic [W:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_xor
        assign chain[i+1] = chain[i] ^ dat[i];
    end

    assign gen_par  = ~chain[W];
    assign res.take = stb;
    assign res.bad  = stb & ~(chain[W] ^ par);

    always_comb begin
        if (stb && (W == scsi_par_pkg::DEF_DW))
            AST_GEN_MATCH: assert (res.bad == (gen_par != par)); // R10
    end
endmodule

// File: rtl/atn_ctrl.sv
module atn_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic rx_bad,
    input  logic initiator,
    input  logic chk_en,
    input  logic auto_atn_en,
    input  logic man_atn,
    input  logic sel_req,
    input  logic sel_timeout,
    input  logic phase_chg,
    output logic sel_out,
    output logic atn_out
);
    logic to_q;
    logic auto_q;
    logic auto_hit;
    logic man_term;
    logic auto_term;

    assign auto_hit  = rx_bad & initiator & chk_en & auto_atn_en;
    assign sel_out   = sel_req & ~sel_timeout & ~to_q;
    assign man_term  = man_atn & (~sel_req | sel_out);
    assign auto_term = initiator & (auto_q | auto_hit);
    assign atn_out   = man_term | auto_term;

    always_ff @(posedge clk) begin
        if (rst) begin
            to_q   <= 1'b0;
            auto_q <= 1'b0;
        end else begin
            if (!sel_req)
                to_q <= 1'b0;
            else if (sel_timeout)
                to_q <= 1'b1;
            if (auto_hit)
                auto_q <= 1'b1;
            else if (phase_chg)
                auto_q <= 1'b0;
        end
    end

    AST_AUTO_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (rx_bad && initiator && chk_en && auto_atn_en) |-> atn_out); // R5
    AST_NO_AUTO_TARGET: assert property (@(posedge clk) disable iff (rst)
        (!initiator && !man_atn) |-> !atn_out); // R6
    AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (auto_q && !phase_chg) |=> auto_q); // R7
    AST_TIMEOUT_DROP: assert property (@(posedge clk) disable iff (rst)
        (sel_timeout && sel_req && !auto_term) |-> (!sel_out && !atn_out)); // R8
endmodule

// File: rtl/perr_status.sv
module perr_status (
    input  logic clk,
    input  logic rst,
    input  scsi_par_pkg::chk_res_t rx_res,
    input  scsi_par_pkg::chk_res_t fifo_res,
    input  logic chk_en,
    input  logic clr_stb,
    input  logic irq_mask_en,
    output logic perr_stat,
    output logic irq
);
    logic err_now;

    assign err_now = chk_en & (rx_res.bad | fifo_res.bad);
    assign irq     = perr_stat & irq_mask_en;

    always_ff @(posedge clk) begin
        if (rst)
            perr_stat <= 1'b0;
        else if (err_now)
            perr_stat <= 1'b1;
        else if (clr_stb)
            perr_stat <= 1'b0;
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (perr_stat && !clr_stb) |=> perr_stat); // R3
    AST_NO_REPORT_OFF: assert property (@(posedge clk) disable iff (rst)
        (!chk_en && !perr_stat) |=> !perr_stat); // R2
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> irq_mask_en); // R4
endmodule

// File: rtl/rx_parity_attn.sv
module rx_parity_attn #(
    parameter int DW = scsi_par_pkg::DEF_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] rx_dat,
    input  logic          rx_par,
    input  logic          byte_stb,
    input  logic          ack_in,
    input  logic          initiator,
    input  logic          chk_en,
    input  logic          auto_atn_en,
    input  logic          man_atn,
    input  logic          sel_req,
    input  logic          sel_timeout,
    input  logic          phase_chg,
    input  logic          clr_stb,
    input  logic          irq_mask_en,
    input  logic [DW-1:0] fifo_dat,
    input  logic          fifo_par,
    input  logic          fifo_stb,
    output logic          host_par,
    output logic          sel_out,
    output logic          atn_out,
    output logic          perr_stat,
    output logic          irq
);
    import scsi_par_pkg::*;

    chk_res_t rx_res;
    chk_res_t fifo_res;
    logic     rx_gen_unused;

    par_checker #(.W(DW)) u_rx_chk (
        .dat(rx_dat), .par(rx_par), .stb(byte_stb & ack_in),
        .res(rx_res), .gen_par(rx_gen_unused)
    );

    par_checker #(.W(DW)) u_fifo_chk (
        .dat(fifo_dat), .par(fifo_par), .stb(fifo_stb),
        .res(fifo_res), .gen_par(host_par)
    );

    atn_ctrl u_atn (
        .clk(clk), .rst(rst), .rx_bad(rx_res.bad), .initiator(initiator),
        .chk_en(chk_en), .auto_atn_en(auto_atn_en), .man_atn(man_atn),
        .sel_req(sel_req), .sel_timeout(sel_timeout), .phase_chg(phase_chg),
        .sel_out(sel_out), .atn_out(atn_out)
    );

    perr_status u_stat (
        .clk(clk), .rst(rst), .rx_res(rx_res), .fifo_res(fifo_res),
        .chk_en(chk_en), .clr_stb(clr_stb), .irq_mask_en(irq_mask_en),
        .perr_stat(perr_stat), .irq(irq)
    );

    AST_RX_SETS_STAT: assert property (@(posedge clk) disable iff (rst)
        (chk_en && byte_stb && ack_in && !(^{rx_dat, rx_par})) |=> perr_stat); // R1
    AST_FIFO_SETS_STAT: assert property (@(posedge clk) disable iff (rst)
        (chk_en && fifo_stb && !(^{fifo_dat, fifo_par})) |=> perr_stat); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!perr_stat && !irq)); // R11
endmodule

// File: tb/sim_rx_parity_attn.sv
module sim_rx_parity_attn;
    logic clk = 1'b0;
    logic rst;
    logic [7:0] rx_dat, fifo_dat;
    logic rx_par, byte_stb, ack_in, initiator, chk_en, auto_atn_en, man_atn;
    logic sel_req, sel_timeout, phase_chg, clr_stb, irq_mask_en, fifo_par, fifo_stb;
    logic host_par, sel_out, atn_out, perr_stat, irq;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rx_parity_attn #(.DW(8)) u0 (
        .clk(clk), .rst(rst), .rx_dat(rx_dat), .rx_par(rx_par), .byte_stb(byte_stb),
        .ack_in(ack_in), .initiator(initiator), .chk_en(chk_en),
        .auto_atn_en(auto_atn_en), .man_atn(man_atn), .sel_req(sel_req),
        .sel_timeout(sel_timeout), .phase_chg(phase_chg), .clr_stb(clr_stb),
        .irq_mask_en(irq_mask_en), .fifo_dat(fifo_dat), .fifo_par(fifo_par),
        .fifo_stb(fifo_stb), .host_par(host_par), .sel_out(sel_out),
        .atn_out(atn_out), .perr_stat(perr_stat), .irq(irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic good_par(input logic [7:0] d);
        logic x = 1'b0;
        for (int i = 0; i < 8; i++) x = x ^ d[i];
        return ~x;
    endfunction

    task automatic idle();
        rx_dat = 0; rx_par = 1; byte_stb = 0; ack_in = 0; initiator = 1;
        chk_en = 0; auto_atn_en = 0; man_atn = 0; sel_req = 0; sel_timeout = 0;
        phase_chg = 0; clr_stb = 0; irq_mask_en = 0; fifo_dat = 0; fifo_par = 1;
        fifo_stb = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1; idle();
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    // send a byte with ack high (or low), bad=1 flips parity; returns atn in strobe cycle
    task automatic send(input logic [7:0] d, input bit bad, input logic ack, output logic atn_seen);
        rx_dat = d; rx_par = good_par(d) ^ bad; byte_stb = 1; ack_in = ack;
        #1 atn_seen = atn_out;
        @(negedge clk); byte_stb = 0; ack_in = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R11 atn", atn_out, 0); chk("R11 sel", sel_out, 0);
        chk("R11 perr", perr_stat, 0); chk("R11 irq", irq, 0);
    endtask

    task automatic t_host_par();
        int bad = 0;
        for (int v = 0; v < 256; v++) begin
            fifo_dat = v[7:0]; #1;
            if (host_par !== good_par(v[7:0])) bad++;
        end
        chk("R10 sweep", bad == 0, 1);
        fifo_dat = 0;
    endtask

    task automatic t_rx_basic();
        logic a;
        do_reset(); chk_en = 1;
        send(8'h5A, 0, 1, a); chk("R1 good byte", perr_stat, 0);
        send(8'h33, 1, 0, a); chk("R1 ack low ignored", perr_stat, 0);
        send(8'hC3, 1, 1, a); chk("R6 auto off atn", a, 0);
        chk("R1 bad byte", perr_stat, 1);
        chk("R4 masked irq", irq, 0);
        irq_mask_en = 1; #1 chk("R4 unmasked irq", irq, 1);
        @(negedge clk); chk("R3 sticky", perr_stat, 1);
        clr_stb = 1; @(negedge clk); clr_stb = 0;
        chk("R3 cleared", perr_stat, 0); chk("R4 irq off", irq, 0);
        clr_stb = 1; rx_dat = 8'h01; rx_par = 1; byte_stb = 1; ack_in = 1;
        @(negedge clk); clr_stb = 0; byte_stb = 0; ack_in = 0;
        chk("R3 set wins", perr_stat, 1);
    endtask

    task automatic t_chk_off();
        logic a;
        do_reset(); auto_atn_en = 1; initiator = 1;
        send(8'h77, 1, 1, a);
        chk("R2 no status", perr_stat, 0); chk("R6 chk off atn", a, 0);
        fifo_dat = 8'h10; fifo_par = 1; fifo_stb = 1;
        @(negedge clk); fifo_stb = 0;
        chk("R2 fifo no status", perr_stat, 0);
    endtask

    task automatic t_auto();
        logic a;
        do_reset(); chk_en = 1; auto_atn_en = 1; initiator = 1;
        send(8'h81, 1, 1, a);
        chk("R5 atn with ack", a, 1);
        chk("R7 held", atn_out, 1);
        send(8'h12, 0, 1, a);
        chk("R7 held through transfer", atn_out, 1);
        phase_chg = 1; @(negedge clk); phase_chg = 0;
        chk("R7 released", atn_out, 0);
        send(8'h00, 1, 1, a);
        man_atn = 1; phase_chg = 1; @(negedge clk); phase_chg = 0;
        chk("R7 manual keeps", atn_out, 1);
        man_atn = 0; #1 chk("R7 manual off", atn_out, 0);
    endtask

    task automatic t_target();
        logic a;
        do_reset(); chk_en = 1; auto_atn_en = 1; initiator = 0;
        send(8'hF0, 1, 1, a);
        chk("R6 target atn", a, 0); chk("R6 target after", atn_out, 0);
        chk("R1 target status", perr_stat, 1);
    endtask

    task automatic t_fifo();
        do_reset(); chk_en = 1;
        fifo_dat = 8'h3C; fifo_par = good_par(8'h3C); fifo_stb = 1;
        @(negedge clk); chk("R9 good fifo", perr_stat, 0);
        fifo_par = ~fifo_par; @(negedge clk); fifo_stb = 0;
        chk("R9 bad fifo", perr_stat, 1);
    endtask

    task automatic t_sel();
        do_reset();
        sel_req = 1; man_atn = 0; #1
        chk("R8 sel no atn", atn_out, 0); chk("R8 sel out", sel_out, 1);
        man_atn = 1; #1 chk("R8 sel atn", atn_out, 1);
        @(negedge clk); sel_timeout = 1; #1
        chk("R8 timeout sel", sel_out, 0); chk("R8 timeout atn", atn_out, 0);
        @(negedge clk); sel_timeout = 0; #1
        chk("R8 stays low", atn_out, 0); chk("R8 sel low", sel_out, 0);
        @(negedge clk); sel_req = 0; #1
        chk("R8 after sel", atn_out, 1);
        @(negedge clk); man_atn = 0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; idle();
        t_reset(); t_host_par(); t_rx_basic(); t_chk_off();
        t_auto(); t_target(); t_fifo(); t_sel();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule